// File: doc/BRIEF.md
# Restartable Pixel Clock Divider

This block takes a fast synthesized clock and derives a pixel clock from it. It applies a coarse pre-division of 1, 2 or 4, then an integer modulus chosen from a fixed set. The resulting waveform is exactly half high and half low, including for odd totals. To reach the half-cycle resolution that odd totals need, the block also uses the falling edge of the fast clock.

The pixel clock is started by an external enable pin, for example a conditioned beam-detect pulse. When the pin reaches its active level, the divider restarts in phase with the fast clock. The pixel clock runs for as long as the pin stays active. After the pin is released, the clock finishes the cycle in progress and then rests high. The pin's active level is selectable. A suppress bit holds the output low.

Top module: `pixclk_divider`

## Requirements
- R1: After reset the divider is idle and `pix_clk` is high.
- R2: `cfg_mod` picks the modulus M. The codes 0 to 8 select 3, 4, 5, 6, 8, 10, 12, 16 and 20 in that order, and codes 9 to 15 select 20. The pixel period is N = M × P fast-clock cycles, where P is the post-scale ratio.
- R3: Each pixel period has a low phase and a high phase of N/2 fast-clock cycles each. For odd N, the low phase starts on a falling edge of `clk_fast` and lasts N/2 cycles, a whole number of cycles plus one half.
- R4: A restart works as follows. The pin is first sampled active at rising edge e0. Two rising edges later, the low phase begins: at that edge for even N, or half a fast cycle after it for odd N.
- R5: With `cfg_pol` = 1 the pin is active high. With `cfg_pol` = 0 it is active low. A restart needs a transition from inactive to active.
- R6: While the pin stays active, periods follow one another without a gap. Once the pin is inactive, the current period completes and `pix_clk` then stays high.
- R7: A new active edge restarts the phase only while the divider is idle. If the pin becomes active again before the running period ends, the divider keeps its phase and runs on.
- R8: `cfg_post` selects P: code 0 gives P = 1, code 1 gives P = 2, and codes 2 and 3 give P = 4.
- R9: `cfg_suppress` = 1 holds `pix_clk` low. The divider keeps its phase while suppressed, and the waveform reappears in that phase when the bit clears.
- R10: `cfg_mod` and `cfg_post` are captured at a restart. Changes made while the divider is running have no effect until the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast synthesized clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Asynchronous enable / restart pin |
| cfg_mod | input | 4 | Modulus code |
| cfg_post | input | 2 | Post-scale code |
| cfg_pol | input | 1 | Enable active level (1 = high) |
| cfg_suppress | input | 1 | Force pixel clock low |
| pix_clk | output | 1 | Pixel clock |

## Verification
The checker examines four things on every rising edge: that the output is high whenever the divider is idle and not suppressed, that it is low whenever suppressed, that the period counter stays inside the captured period, and that the captured period stays constant and wraps only at its last count while running. Other properties can only be shown by the bench. Comparing against its reference model at every half cycle, it covers the half-cycle shape of odd periods, the exact restart latency through the synchronizer, the behaviour of both polarities, a re-assertion before the cycle completes, and the mid-run configuration changes that must not take effect.

// File: rtl/pixclk_divider.sv
module pixclk_divider #(
  parameter int CW = 7
) (
  input  logic          clk_fast,
  input  logic          rst_n,
  input  logic          en_pin,
  input  logic [3:0]    cfg_mod,
  input  logic [1:0]    cfg_post,
  input  logic          cfg_pol,
  input  logic          cfg_suppress,
  output logic          pix_clk
);

  function automatic logic [CW-1:0] mod_of(input logic [3:0] c);
    case (c)
      4'd0:    mod_of = CW'(3);
      4'd1:    mod_of = CW'(4);
      4'd2:    mod_of = CW'(5);
      4'd3:    mod_of = CW'(6);
      4'd4:    mod_of = CW'(8);
      4'd5:    mod_of = CW'(10);
      4'd6:    mod_of = CW'(12);
      4'd7:    mod_of = CW'(16);
      default: mod_of = CW'(20);
    endcase
  endfunction

  logic          sy1_q, sy2_q, act_d_q;
  logic          run_q, lo_p_q, lo_n_q, odd_q;
  logic [CW-1:0] cnt_q, n_q;

  logic          act, start;
  logic [1:0]    post_sh;
  logic [CW-1:0] n_req, half, cnt_nx, last;

  assign act     = cfg_pol ? sy2_q : ~sy2_q;
  assign start   = act & ~act_d_q & ~run_q;
  assign post_sh = (cfg_post == 2'd0) ? 2'd0 : (cfg_post == 2'd1) ? 2'd1 : 2'd2;
  assign n_req   = mod_of(cfg_mod) << post_sh;
  assign half    = CW'((n_q + 1'b1) >> 1);
  assign cnt_nx  = cnt_q + 1'b1;
  assign last    = n_q - 1'b1;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q   <= 1'b0;
      sy2_q   <= 1'b0;
      act_d_q <= 1'b1;
    end else begin
      sy1_q   <= en_pin;
      sy2_q   <= sy1_q;
      act_d_q <= act;
    end
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      n_q    <= CW'(3);
      odd_q  <= 1'b0;
      lo_p_q <= 1'b0;
    end else if (start) begin
      run_q  <= 1'b1;
      cnt_q  <= '0;
      n_q    <= n_req;
      odd_q  <= n_req[0];
      lo_p_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == last) begin
        cnt_q <= '0;
        if (act) begin
          lo_p_q <= 1'b1;
        end else begin
          run_q  <= 1'b0;
          lo_p_q <= 1'b0;
        end
      end else begin
        cnt_q  <= cnt_nx;
        lo_p_q <= (cnt_nx < half);
      end
    end
  end

  always_ff @(negedge clk_fast or negedge rst_n) begin
    if (!rst_n) lo_n_q <= 1'b0;
    else        lo_n_q <= lo_p_q;
  end

  assign pix_clk = ~cfg_suppress & ~(lo_p_q & (lo_n_q | ~odd_q));

endmodule

// File: rtl/pixclk_divider_chk.sv
module pixclk_divider_chk #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] n_q,
  input logic          cfg_suppress,
  input logic          pix_clk
);

  p_park_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cfg_suppress) |-> pix_clk);

  p_suppress_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_suppress |-> !pix_clk);

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < n_q));

  p_no_midcycle_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && cnt_q == '0) |-> (CW'($past(cnt_q) + 1'b1) == $past(n_q)));

  p_cfg_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> $stable(n_q));

endmodule

bind pixclk_divider pixclk_divider_chk #(.CW(CW)) u_chk (
  .clk          (clk_fast),
  .rst_n        (rst_n),
  .run_q        (run_q),
  .cnt_q        (cnt_q),
  .n_q          (n_q),
  .cfg_suppress (cfg_suppress),
  .pix_clk      (pix_clk)
);

// File: tb/pixclk_divider_tb.sv
module pixclk_divider_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_pin = 1'b0;
  logic [3:0] cfg_mod = 4'd0;
  logic [1:0] cfg_post = 2'd0;
  logic       cfg_pol = 1'b1;
  logic       cfg_suppress = 1'b0;
  logic       pix_clk;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  int m_s1 = 0, m_s2 = 0, m_actp = 1, m_run = 0, m_ph = 0, m_n = 3, m_act;

  pixclk_divider dut_i (
    .clk_fast(clk), .rst_n(rst_n), .en_pin(en_pin), .cfg_mod(cfg_mod),
    .cfg_post(cfg_post), .cfg_pol(cfg_pol), .cfg_suppress(cfg_suppress),
    .pix_clk(pix_clk)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int mod_val(input int c);
    int t[9] = '{3, 4, 5, 6, 8, 10, 12, 16, 20};
    return (c > 8) ? 20 : t[c];
  endfunction

  function automatic int post_val(input int c);
    return (c == 0) ? 1 : (c == 1) ? 2 : 4;
  endfunction

  task automatic compare();
    logic exp_v;
    bit low;
    if (!rst_n || done) return;
    if (m_n % 2 == 1) low = (m_run != 0) && m_ph >= 1 && m_ph <= m_n;
    else              low = (m_run != 0) && m_ph < m_n;
    exp_v = cfg_suppress ? 1'b0 : !low;
    n_checks++;
    if (pix_clk !== exp_v) begin
      n_fail++;
      $display("FAIL %s t=%0t pix_clk=%0b expected=%0b", cur_req, $time, pix_clk, exp_v);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_actp = 1; m_run = 0; m_ph = 0;
    end else begin
      m_act = cfg_pol ? m_s2 : (m_s2 == 0 ? 1 : 0);
      if (m_run == 0 && m_act != 0 && m_actp == 0) begin
        m_run = 1;
        m_n   = mod_val(int'(cfg_mod)) * post_val(int'(cfg_post));
        m_ph  = 0;
      end else if (m_run != 0) begin
        m_ph++;
        if (m_ph == 2 * m_n) begin
          if (m_act != 0) m_ph = 0;
          else            m_run = 0;
        end
      end
      m_actp = m_act;
      m_s2   = m_s1;
      m_s1   = int'(en_pin);
    end
    #2 compare();
  end

  always @(negedge clk) begin
    if (rst_n && m_run != 0) m_ph++;
    #2 compare();
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_pin(input bit active);
    en_pin = active ? cfg_pol : ~cfg_pol;
  endtask

  task automatic burst(input int hold, input int rest);
    set_pin(1'b1);
    wait_cyc(hold);
    set_pin(1'b0);
    wait_cyc(rest);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_up();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    cur_req = "R1";
    n_checks++;
    if (pix_clk !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset pix_clk=%0b expected=1", pix_clk);
    end
    wait_cyc(4);

    // R2 R3 R4 R6: every modulus code, no post-scale
    for (int c = 0; c < 10; c++) begin
      cur_req = "R2 R3 R4 R6";
      cfg_mod = 4'(c);
      burst(2 * mod_val(c) + 7, 2 * mod_val(c) + 10);
    end

    // R8: post-scale codes on odd and even moduli
    for (int p = 1; p < 4; p++) begin
      cur_req = "R8";
      cfg_post = 2'(p);
      cfg_mod = 4'd2;
      burst(40, 60);
      cfg_mod = 4'd1;
      burst(30, 40);
    end
    cfg_post = 2'd0;

    // R5: active-low enable
    cur_req = "R5";
    cfg_pol = 1'b0;
    en_pin = 1'b1;
    wait_cyc(6);
    cfg_mod = 4'd2;
    burst(18, 20);
    cfg_mod = 4'd3;
    burst(25, 20);
    cfg_pol = 1'b1;
    en_pin = 1'b0;
    wait_cyc(6);

    // R7: re-assertion before the period ends keeps the phase
    cur_req = "R7";
    cfg_mod = 4'd7;
    set_pin(1'b1);
    wait_cyc(21);
    set_pin(1'b0);
    wait_cyc(4);
    set_pin(1'b1);
    wait_cyc(30);
    set_pin(1'b0);
    wait_cyc(40);

    // R7: short pulse runs one period then idles
    cfg_mod = 4'd0;
    burst(1, 12);

    // R10: configuration changes mid-run are ignored
    cur_req = "R10";
    cfg_mod = 4'd3;
    set_pin(1'b1);
    wait_cyc(5);
    cfg_mod = 4'd8;
    cfg_post = 2'd2;
    wait_cyc(30);
    set_pin(1'b0);
    wait_cyc(40);
    cfg_post = 2'd0;
    burst(50, 50);

    // R9: suppress during a run
    cur_req = "R9";
    cfg_mod = 4'd2;
    set_pin(1'b1);
    wait_cyc(7);
    cfg_suppress = 1'b1;
    wait_cyc(11);
    cfg_suppress = 1'b0;
    wait_cyc(13);
    set_pin(1'b0);
    wait_cyc(20);

    finish_up();
  end
endmodule